// File: doc/BRIEF.md
# Dual-Mode Encoded Output Link Framer

This block takes 32-bit words from a set of per-section FIFOs and sends each one as four 8b10b symbols (40 bits) on a serial link. Each link emits two bits per clock, a first half and a second half, which a double-data-rate output stage drives out on the two edges of the link clock. The bytes of a word go out most significant first. Running disparity carries on from one symbol to the next and from one word to the next. When a link's source FIFO is empty at a word boundary, the link sends a sync word instead of data. The sync word is four comma symbols, so the receiver stays aligned.

A single `low_rate` input picks one of two modes. In high-rate mode every section has its own link, and all links run in parallel. In low-rate mode, link 0 alone carries traffic: it takes words from the non-empty section FIFOs in round-robin order. The other links are frozen through their clock enables, their transceiver enables go low, and their outputs stay quiet. A mode change takes effect only at a word boundary, so a packet already on the wire is never cut. A 3-bit drive-strength setting is registered and passed on to the link drivers.

All links share one symbol phase, so every link reaches a word boundary in the same cycle. A word boundary comes every 20 clocks, and the first one is in the first cycle after reset is released.

Top module: `link_framer`

## Requirements
- R1: A word takes exactly 20 clock cycles, 5 bit pairs for each of its 4 symbols. FIFO pops happen only in the word-boundary cycle. Bit `link_bits[2i+1]` is the earlier bit of a pair. A symbol's bits go out in the order a,b,c,d,e,i,f,g,h,j.
- R2: Data bytes are sent most significant byte first. Each byte uses the standard 8b10b data code, including the alternate x.7 codes. Running disparity starts negative after reset and carries across symbols and words.
- R3: A link with nothing to send at a word boundary sends four K28.5 symbols: 0011111010 when running disparity is negative, 1100000101 when it is positive.
- R4: In high-rate mode (`low_rate`=0), each link i pops `sec_pop[i]` at every word boundary where `sec_empty[i]` is 0 and sends `sec_data` slice i. It never pops an empty FIFO.
- R5: In low-rate mode, link 0 pops exactly one non-empty section per word boundary. It picks the first non-empty section after the one it served last, in rising index order with wrap-around. After reset the search starts at section 0. If every section is empty, nothing is popped.
- R6: While low-rate mode is in force, links 1..N-1 output 00 and have `link_on` low, and their encoder state is held. When high-rate mode returns, each of them resumes with the running disparity it had before.
- R7: `low_rate` is sampled only in the word-boundary cycle. It governs the word that starts at that boundary. The pair sent in the boundary cycle belongs to the previous word, under the previous mode.
- R8: `drive_lvl` equals `drive_cfg` one clock later.
- R9: During reset all pops are 0, all link outputs are 00 and all links are enabled. The first cycle after release emits 00 on every link and is a word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_rate | input | 1 | 1 selects single-link merged mode |
| drive_cfg | input | 3 | Drive-strength setting |
| sec_empty | input | NSEC | Empty flag of each section FIFO |
| sec_data | input | NSEC*WB | Head word of each section FIFO (show-ahead), slice i for section i |
| sec_pop | output | NSEC | Pop strobe to each section FIFO |
| link_bits | output | 2*NSEC | Bit pair per link, bit 2i+1 sent first |
| link_on | output | NSEC | Clock and transceiver enable per link |
| drive_lvl | output | 3 | Registered drive strength |

## Verification
A pop belongs to the cycle of the word boundary and is checked at that cycle's falling edge, against the bench's own FIFO occupancy and round-robin pointer. The 20 bit pairs of the word chosen there appear in the 20 following cycles. The bench gathers them at falling edges and compares the whole 40-bit word at the falling edge of the next boundary cycle, 20 cycles after the pop. It checks `link_on` at mid-word, and it checks `drive_lvl` just after the edge that follows a change of `drive_cfg`. Mode switches are applied mid-word, so the check lands on the word that begins at the next boundary.

// File: rtl/link_framer.sv
module link_framer #(
  parameter int NSEC = 16,
  parameter int WB   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 low_rate,
  input  logic [2:0]           drive_cfg,
  input  logic [NSEC-1:0]      sec_empty,
  input  logic [NSEC*WB-1:0]   sec_data,
  output logic [NSEC-1:0]      sec_pop,
  output logic [2*NSEC-1:0]    link_bits,
  output logic [NSEC-1:0]      link_on,
  output logic [2:0]           drive_lvl
);
  localparam int NB = WB / 8;
  localparam int BW = $clog2(NB);
  localparam int IW = $clog2(NSEC);

  function automatic logic [10:0] enc(input logic [7:0] d, input logic kc, input logic rd);
    logic [5:0] s;
    logic [3:0] f;
    logic r1, r2;
    if (kc) return rd ? {1'b0, 10'b1100000101} : {1'b1, 10'b0011111010};
    case (d[4:0])
      5'd0: s = 6'b100111;  5'd1: s = 6'b011101;  5'd2: s = 6'b101101;  5'd3: s = 6'b110001;
      5'd4: s = 6'b110101;  5'd5: s = 6'b101001;  5'd6: s = 6'b011001;  5'd7: s = 6'b111000;
      5'd8: s = 6'b111001;  5'd9: s = 6'b100101;  5'd10: s = 6'b010101; 5'd11: s = 6'b110100;
      5'd12: s = 6'b001101; 5'd13: s = 6'b101100; 5'd14: s = 6'b011100; 5'd15: s = 6'b010111;
      5'd16: s = 6'b011011; 5'd17: s = 6'b100011; 5'd18: s = 6'b010011; 5'd19: s = 6'b110010;
      5'd20: s = 6'b001011; 5'd21: s = 6'b101010; 5'd22: s = 6'b011010; 5'd23: s = 6'b111010;
      5'd24: s = 6'b110011; 5'd25: s = 6'b100110; 5'd26: s = 6'b010110; 5'd27: s = 6'b110110;
      5'd28: s = 6'b001110; 5'd29: s = 6'b101110; 5'd30: s = 6'b011110; default: s = 6'b101011;
    endcase
    if (rd && ($countones(s) != 3 || d[4:0] == 5'd7)) s = ~s;
    r1 = ($countones(s) != 3) ? ~rd : rd;
    case (d[7:5])
      3'd0: f = 4'b1011; 3'd1: f = 4'b1001; 3'd2: f = 4'b0101; 3'd3: f = 4'b1100;
      3'd4: f = 4'b1101; 3'd5: f = 4'b1010; 3'd6: f = 4'b0110; default: f = 4'b1110;
    endcase
    if (d[7:5] == 3'd7 &&
        ((!r1 && (d[4:0] == 5'd17 || d[4:0] == 5'd18 || d[4:0] == 5'd20)) ||
         ( r1 && (d[4:0] == 5'd11 || d[4:0] == 5'd13 || d[4:0] == 5'd14))))
      f = 4'b0111;
    if (r1 && ($countones(f) != 2 || d[7:5] == 3'd3)) f = ~f;
    r2 = ($countones(f) != 2) ? ~r1 : r1;
    return {r2, s, f};
  endfunction

  logic [2:0]    pc;
  logic [BW-1:0] bi;
  logic          lr_q;
  logic [IW-1:0] rr_q, pick;
  logic [2:0]    drv_q;
  logic          any;

  wire sym_end = (pc == 3'd4);
  wire load    = rst_n && sym_end && (bi == BW'(NB - 1));

  always_comb begin
    int idx;
    pick = rr_q;
    any  = 1'b0;
    for (int k = 1; k <= NSEC; k++) begin
      idx = (int'(rr_q) + k) % NSEC;
      if (!any && !sec_empty[idx]) begin
        any  = 1'b1;
        pick = IW'(idx);
      end
    end
  end

  always_comb begin
    sec_pop = '0;
    if (load) begin
      if (low_rate) begin
        if (any) sec_pop[pick] = 1'b1;
      end else begin
        sec_pop = ~sec_empty;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc    <= 3'd4;
      bi    <= BW'(NB - 1);
      lr_q  <= 1'b0;
      rr_q  <= IW'(NSEC - 1);
      drv_q <= 3'd0;
    end else begin
      drv_q <= drive_cfg;
      pc    <= sym_end ? 3'd0 : pc + 3'd1;
      if (sym_end) bi <= (bi == BW'(NB - 1)) ? '0 : bi + 1'b1;
      if (load) begin
        lr_q <= low_rate;
        if (low_rate && any) rr_q <= pick;
      end
    end

  assign drive_lvl = drv_q;

  for (genvar i = 0; i < NSEC; i++) begin : g_link
    logic [9:0]    sh;
    logic [WB-1:0] w;
    logic          rd, kq;
    wire           on    = (i == 0) || !lr_q;
    wire           ld_on = (i == 0) || !low_rate;
    wire [WB-1:0]  src   = low_rate ? sec_data[pick*WB +: WB] : sec_data[i*WB +: WB];
    wire           has   = low_rate ? any : !sec_empty[i];
    wire           en    = load ? ld_on : on;
    wire [10:0]    e     = enc(load ? src[WB-1 -: 8] : w[WB-1 -: 8], load ? !has : kq, rd);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sh <= '0; w <= '0; rd <= 1'b0; kq <= 1'b0;
      end else if (en) begin
        if (sym_end) begin
          sh <= e[9:0];
          rd <= e[10];
          if (load) begin
            w  <= {src[WB-9:0], 8'h00};
            kq <= !has;
          end else begin
            w <= w << 8;
          end
        end else begin
          sh <= sh << 2;
        end
      end

    assign link_bits[2*i+1 -: 2] = on ? sh[9:8] : 2'b00;
    assign link_on[i] = on;

    AST_SYM_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (on && pc == 3'd0) |-> ($countones(sh) >= 4 && $countones(sh) <= 6)); // R2
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!on && !load) |=> ($stable(sh) && $stable(rd))); // R6
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pop & sec_empty) == '0); // R4
  AST_MERGE_ONEPOP: assert property (@(posedge clk) disable iff (!rst_n)
    low_rate |-> $onehot0(sec_pop)); // R5
  AST_POP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|sec_pop) |-> (pc == 3'd4)); // R1
  AST_MODE_AT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lr_q)); // R7
endmodule

// File: tb/test_link_framer.sv
`timescale 1ns/100ps
module test_link_framer;
  localparam int N = 4, WB = 32;
  logic clk = 1'b0, rst_n = 1'b0, low_rate = 1'b0;
  logic [2:0] drive_cfg = 3'd0;
  logic [N-1:0] sec_empty;
  logic [N*WB-1:0] sec_data;
  wire  [N-1:0] sec_pop;
  wire  [2*N-1:0] link_bits;
  wire  [N-1:0] link_on;
  wire  [2:0] drive_lvl;

  link_framer #(.NSEC(N), .WB(WB)) i_link_framer (
    .clk(clk), .rst_n(rst_n), .low_rate(low_rate), .drive_cfg(drive_cfg),
    .sec_empty(sec_empty), .sec_data(sec_data), .sec_pop(sec_pop),
    .link_bits(link_bits), .link_on(link_on), .drive_lvl(drive_lvl));

  always #2.5 clk = ~clk;

  logic [WB-1:0] mem [N][256];
  int hd [N];
  int tl [N];
  int ntot = 0, nbad = 0, c = 0;
  bit run = 0, done = 0, midpop = 0, mode_cur = 0;
  bit rdm [N];
  bit gated [N];
  logic [39:0] expw [N];
  logic [39:0] rxw [N];
  string tagk [N];
  int rr_m = N - 1;

  initial for (int i = 0; i < N; i++) begin hd[i] = 0; tl[i] = 0; rdm[i] = 0; gated[i] = 0; end

  for (genvar i = 0; i < N; i++) begin : g_fifo
    assign sec_empty[i] = (hd[i] == tl[i]);
    assign sec_data[i*WB +: WB] = mem[i][hd[i] & 255];
    always @(posedge clk) if (sec_pop[i]) hd[i] <= hd[i] + 1;
  end

  always @(posedge clk) if (run) c <= c + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int s, input logic [31:0] v);
    mem[s][tl[s] & 255] = v;
    tl[s]++;
  endtask

  function automatic logic [10:0] sym(input logic [7:0] d, input bit k, input bit rd);
    logic [5:0] a;
    logic [3:0] b;
    bit r;
    if (k) return rd ? 11'b0_1100000101 : 11'b1_0011111010;
    case (d[4:0])
      0: a = 6'b100111;  1: a = 6'b011101;  2: a = 6'b101101;  3: a = 6'b110001;
      4: a = 6'b110101;  5: a = 6'b101001;  6: a = 6'b011001;  7: a = 6'b111000;
      8: a = 6'b111001;  9: a = 6'b100101;  10: a = 6'b010101; 11: a = 6'b110100;
      12: a = 6'b001101; 13: a = 6'b101100; 14: a = 6'b011100; 15: a = 6'b010111;
      16: a = 6'b011011; 17: a = 6'b100011; 18: a = 6'b010011; 19: a = 6'b110010;
      20: a = 6'b001011; 21: a = 6'b101010; 22: a = 6'b011010; 23: a = 6'b111010;
      24: a = 6'b110011; 25: a = 6'b100110; 26: a = 6'b010110; 27: a = 6'b110110;
      28: a = 6'b001110; 29: a = 6'b101110; 30: a = 6'b011110; default: a = 6'b101011;
    endcase
    r = rd;
    if ($countones(a) != 3) begin if (r) a = ~a; r = !r; end
    else if (d[4:0] == 7 && r) a = ~a;
    case (d[7:5])
      0: b = 4'b1011; 1: b = 4'b1001; 2: b = 4'b0101; 3: b = 4'b1100;
      4: b = 4'b1101; 5: b = 4'b1010; 6: b = 4'b0110; default: b = 4'b1110;
    endcase
    if (d[7:5] == 7 && (r ? (d[4:0] inside {11, 13, 14}) : (d[4:0] inside {17, 18, 20}))) b = 4'b0111;
    if ($countones(b) != 2) begin if (r) b = ~b; r = !r; end
    else if (d[7:5] == 3 && r) b = ~b;
    return {r, a, b};
  endfunction

  function automatic logic [40:0] encw(input logic [31:0] v, input bit k, input bit rd);
    logic [39:0] o;
    logic [10:0] s;
    bit r;
    r = rd;
    o = '0;
    for (int j = 3; j >= 0; j--) begin
      s = sym(v[8*j +: 8], k, r);
      r = s[10];
      o = {o[29:0], s[9:0]};
    end
    return {r, o};
  endfunction

  always @(negedge clk) begin
    if (run && !done) begin
      logic [N-1:0] ep;
      for (int i = 0; i < N; i++) rxw[i] = {rxw[i][37:0], link_bits[2*i+1], link_bits[2*i]};
      if (c % 20 != 0 && sec_pop != '0) midpop = 1;
      if (c == 0) chk(link_bits == '0, "R9 filler pair after release", link_bits, 0);
      if (c % 20 == 10)
        chk(link_on == (mode_cur ? N'(1) : {N{1'b1}}), "R6,R7 link enables for this word",
            link_on, mode_cur ? N'(1) : {N{1'b1}});
      if (c % 20 == 0) begin
        if (c > 0) begin
          for (int i = 0; i < N; i++) chk(rxw[i] == expw[i], tagk[i], rxw[i], expw[i]);
          chk(!midpop, "R1 pops only at word boundary", midpop, 0);
          midpop = 0;
        end
        mode_cur = low_rate;
        ep = '0;
        for (int i = 0; i < N; i++) begin
          if (!mode_cur) begin
            bit k;
            k = (hd[i] == tl[i]);
            if (!k) ep[i] = 1'b1;
            {rdm[i], expw[i]} = encw(k ? 32'h0 : mem[i][hd[i] & 255], k, rdm[i]);
            tagk[i] = k ? "R3 sync word" : (gated[i] ? "R6 resumed link word" : "R2 data word");
            gated[i] = 0;
          end else if (i == 0) begin
            int p;
            p = -1;
            for (int s = 1; s <= N; s++)
              if (p < 0 && hd[(rr_m + s) % N] != tl[(rr_m + s) % N]) p = (rr_m + s) % N;
            if (p >= 0) begin
              ep[p] = 1'b1;
              rr_m = p;
              {rdm[0], expw[0]} = encw(mem[p][hd[p] & 255], 0, rdm[0]);
              tagk[0] = "R5 merged word";
            end else begin
              {rdm[0], expw[0]} = encw(32'h0, 1, rdm[0]);
              tagk[0] = "R3 sync word in merged mode";
            end
          end else begin
            expw[i] = '0;
            tagk[i] = "R6 gated link quiet";
            gated[i] = 1;
          end
        end
        chk(sec_pop == ep, mode_cur ? "R5 merge pop" : "R4 section pop", sec_pop, ep);
      end
    end
  end

  task automatic wait_phase(input int p);
    do begin @(posedge clk); #1; end while (c % 20 != p);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", ntot - nbad, ntot);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int j = 0; j < 64; j++)
      push(0, {8'(4*j), 8'(4*j + 1), 8'(4*j + 2), 8'(4*j + 3)});
    push(1, 32'h00000000); push(1, 32'hFFFFFFFF); push(1, 32'hF1F1F1F1);
    push(1, 32'hEBEBEBEB); push(1, 32'hF2EDF4EE); push(1, 32'h07070707);
    push(1, 32'hFC1C3C7C);
    for (int j = 0; j < 20; j++) push(2, 32'h9E3779B9 * (j + 1));
    repeat (3) @(posedge clk);
    #1;
    chk(sec_pop == '0 && link_bits == '0 && link_on == '1, "R9 reset outputs",
        {sec_pop, link_bits, link_on}, {4'h0, 8'h00, 4'hF});
    @(posedge clk); #1;
    rst_n = 1'b1;
    run = 1'b1;
    repeat (70 * 20) @(posedge clk);
    #1;
    wait_phase(7);
    low_rate = 1'b1;
    for (int j = 0; j < 3; j++) push(1, 32'h11110000 + j);
    for (int j = 0; j < 2; j++) push(3, 32'h33330000 + j);
    push(0, 32'h0000ABCD);
    repeat (10 * 20) @(posedge clk);
    #1;
    for (int j = 0; j < 4; j++) begin push(0, 32'hA0A0A0A0 + j); push(2, 32'hC2C2C2C2 + j); end
    repeat (10 * 20) @(posedge clk);
    #1;
    wait_phase(13);
    low_rate = 1'b0;
    for (int s = 0; s < N; s++) for (int j = 0; j < 3; j++) push(s, 32'h5A5A0000 + 16 * s + j);
    repeat (6 * 20) @(posedge clk);
    #1;
    wait_phase(3);
    low_rate = 1'b1;
    for (int s = 0; s < N; s++) push(s, 32'h7E7E7E00 + s);
    wait_phase(19);
    low_rate = 1'b0;
    wait_phase(1);
    push(3, 32'hDEADBEEF);
    repeat (6 * 20) @(posedge clk);
    #1;
    for (int v = 0; v < 8; v++) begin
      @(posedge clk); #1; drive_cfg = 3'(7 - v);
      @(posedge clk); #1;
      chk(drive_lvl == 3'(7 - v), "R8 drive level follows one clock later", drive_lvl, 3'(7 - v));
    end
    wait_phase(1);
    finish_run();
  end
endmodule